// File: doc/BRIEF.md
# Address Translation Context Selector and Fault Reporter

This block sits in front of a page-table walker. Each request carries a 64-bit effective address, an access code and the processor mode: hypervisor state, a virtual-hypervisor flag, and the instruction and data relocation enables. If the request is a hypervisor-class access with relocation off for its class, the block answers at once with a real address and full rights. Otherwise it reads the two top address bits as a quadrant. From that quadrant, a table that differs between hypervisor and guest mode gives the partition and process identifiers, and the block passes them to the walker.

A guest access to a quadrant it may not use ends as a segment-class fault. The block also holds the fault-reporting registers. It keeps a faulting data address, a data status word and an instruction fault code. It loads them from its own segment faults and from storage-fault reports that the walker returns on a side port. Requests and responses use valid/ready, and only one request may be in flight.

Top module: `xlat_ctx_frontend`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and `flt_addr`, `flt_status` and `flt_icode` are zero.
- R2: `req_ready` equals the inverse of `rsp_valid`. An accepted request raises `rsp_valid` on the next clock edge. The response fields then hold steady until the edge where `rsp_valid` and `rsp_ready` are both high.
- R3: A bypass happens when `req_hv` or `req_vhyp` is 1 and relocation is off for the access class. A bypass responds with kind 0 (real). `rsp_raddr` is the effective address with its top 4 bits forced to zero. `rsp_perm` is 3'b111, where bit 2 is read, bit 1 is write and bit 0 is execute. `rsp_lpid` and `rsp_pid` are 0.
- R4: A fetch (access code 2) uses `req_ir` as its relocation enable. A read (code 0) or a write (code 1) uses `req_dr`. With both `req_hv` and `req_vhyp` at 0 there is never a bypass.
- R5: In hypervisor mode, when there is no bypass, the response is kind 1 (walk) and takes its identifiers from `req_ea[63:62]`. Quadrant 0 gives (0, `cfg_pid`). Quadrant 1 gives (`cfg_lpid`, `cfg_pid`). Quadrant 2 gives (`cfg_lpid`, 0). Quadrant 3 gives (0, 0). Each pair is (partition, process).
- R6: In guest mode (`req_hv`=0), when there is no bypass, quadrant 0 gives a walk with (`cfg_lpid`, `cfg_pid`). Quadrant 3 gives a walk with (`cfg_lpid`, 0).
- R7: In guest mode without bypass, quadrants 1 and 2 give kind 2 (instruction segment fault) for a fetch and kind 3 (data segment fault) for a read or write. Both clear `flt_icode` to 0. Only kind 3 loads `flt_addr` with the effective address.
- R8: Access code 3 gives kind 4 (illegal) and leaves all fault registers unchanged.
- R9: A storage report (`sf_valid`) for a read or write sets `flt_status` to `sf_cause`. For a write it also sets bit 25 (the store flag). It loads `flt_addr` with `sf_ea` and clears `flt_icode`. The registers show the new values one edge later.
- R10: A storage report for a fetch loads `flt_icode` with `sf_cause` and leaves `flt_addr` and `flt_status` unchanged. A report with access code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request may be accepted |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 fetch, 3 illegal |
| req_hv | input | 1 | Hypervisor state |
| req_vhyp | input | 1 | Virtual-hypervisor mode |
| req_ir | input | 1 | Instruction relocation enable |
| req_dr | input | 1 | Data relocation enable |
| cfg_lpid | input | 12 | Partition ID register |
| cfg_pid | input | 20 | Process ID register |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_kind | output | 3 | 0 real, 1 walk, 2 instr segment fault, 3 data segment fault, 4 illegal |
| rsp_raddr | output | 64 | Real address for kind 0, else 0 |
| rsp_perm | output | 3 | Rights {read, write, execute} for kind 0, else 0 |
| rsp_lpid | output | 12 | Partition ID for the walker |
| rsp_pid | output | 20 | Process ID for the walker |
| rsp_ea | output | 64 | Effective address passed through |
| rsp_acc | output | 2 | Access code passed through |
| sf_valid | input | 1 | Storage fault report from the walker |
| sf_acc | input | 2 | Access code of the faulting access |
| sf_ea | input | 64 | Faulting effective address |
| sf_cause | input | 32 | Cause word |
| flt_addr | output | 64 | Fault address register |
| flt_status | output | 32 | Data fault status register |
| flt_icode | output | 32 | Instruction fault code |

## Verification
The assertions assume that a storage report and a request that causes a segment fault never arrive in the same cycle. When they do, the report wins the address register, and the checks on that register would not describe the result. The assertions also assume the requester holds its fields steady while `req_valid` is high. The stimulus sends storage reports only when no request or response is pending. It changes request fields only at falling edges around a single accept.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    RK_REAL    = 3'd0,
    RK_WALK    = 3'd1,
    RK_ISEG    = 3'd2,
    RK_DSEG    = 3'd3,
    RK_ILLEGAL = 3'd4
  } rkind_e;
endpackage

// File: rtl/xlat_mode_decode.sv
module xlat_mode_decode #(
  parameter int EA_W     = 64,
  parameter int LPID_W   = 12,
  parameter int PID_W    = 20,
  parameter int REAL_CLR = 4
) (
  input  logic [EA_W-1:0]   ea,
  input  logic [1:0]        acc,
  input  logic              hv,
  input  logic              vhyp,
  input  logic              ir,
  input  logic              dr,
  input  logic [LPID_W-1:0] cfg_lpid,
  input  logic [PID_W-1:0]  cfg_pid,
  output logic [2:0]        kind,
  output logic [EA_W-1:0]   raddr,
  output logic [2:0]        perm,
  output logic [LPID_W-1:0] lpid,
  output logic [PID_W-1:0]  pid
);
  import xlat_pkg::*;

  localparam logic [EA_W-1:0] REAL_MASK = {{REAL_CLR{1'b0}}, {(EA_W-REAL_CLR){1'b1}}};

  logic [1:0] quad;
  logic       reloc_on;
  logic       bypass;

  assign quad     = ea[EA_W-1 -: 2];
  assign reloc_on = (acc == ACC_FETCH) ? ir : dr;
  assign bypass   = (hv | vhyp) & ~reloc_on;

  always_comb begin
    kind  = RK_WALK;
    raddr = '0;
    perm  = 3'b000;
    lpid  = '0;
    pid   = '0;
    if (acc == ACC_BAD) begin
      kind = RK_ILLEGAL;
    end else if (bypass) begin
      kind  = RK_REAL;
      raddr = ea & REAL_MASK;
      perm  = 3'b111;
    end else if (hv) begin
      unique case (quad)
        2'd0: pid = cfg_pid;
        2'd1: begin lpid = cfg_lpid; pid = cfg_pid; end
        2'd2: lpid = cfg_lpid;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin lpid = cfg_lpid; pid = cfg_pid; end
        2'd3: lpid = cfg_lpid;
        default: kind = (acc == ACC_FETCH) ? RK_ISEG : RK_DSEG;
      endcase
    end
  end
endmodule

// File: rtl/xlat_fault_regs.sv
module xlat_fault_regs #(
  parameter int EA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seg_data,
  input  logic               seg_any,
  input  logic [EA_W-1:0]    seg_ea,
  input  logic               sf_valid,
  input  logic [1:0]         sf_acc,
  input  logic [EA_W-1:0]    sf_ea,
  input  logic [CAUSE_W-1:0] sf_cause,
  output logic [EA_W-1:0]    flt_addr,
  output logic [CAUSE_W-1:0] flt_status,
  output logic [CAUSE_W-1:0] flt_icode
);
  import xlat_pkg::*;

  localparam logic [CAUSE_W-1:0] STORE_FLAG = CAUSE_W'(1) << STORE_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_addr   <= '0;
      flt_status <= '0;
      flt_icode  <= '0;
    end else begin
      if (seg_any) begin
        flt_icode <= '0;
        if (seg_data) flt_addr <= seg_ea;
      end
      if (sf_valid) begin
        if (sf_acc == ACC_FETCH) begin
          flt_icode <= sf_cause;
        end else if (sf_acc != ACC_BAD) begin
          flt_status <= sf_cause | ((sf_acc == ACC_WRITE) ? STORE_FLAG : '0);
          flt_addr   <= sf_ea;
          flt_icode  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_ctx_frontend.sv
module xlat_ctx_frontend #(
  parameter int EA_W      = 64,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25,
  parameter int REAL_CLR  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [EA_W-1:0]    req_ea,
  input  logic [1:0]         req_acc,
  input  logic               req_hv,
  input  logic               req_vhyp,
  input  logic               req_ir,
  input  logic               req_dr,
  input  logic [LPID_W-1:0]  cfg_lpid,
  input  logic [PID_W-1:0]   cfg_pid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2:0]         rsp_kind,
  output logic [EA_W-1:0]    rsp_raddr,
  output logic [2:0]         rsp_perm,
  output logic [LPID_W-1:0]  rsp_lpid,
  output logic [PID_W-1:0]   rsp_pid,
  output logic [EA_W-1:0]    rsp_ea,
  output logic [1:0]         rsp_acc,
  input  logic               sf_valid,
  input  logic [1:0]         sf_acc,
  input  logic [EA_W-1:0]    sf_ea,
  input  logic [CAUSE_W-1:0] sf_cause,
  output logic [EA_W-1:0]    flt_addr,
  output logic [CAUSE_W-1:0] flt_status,
  output logic [CAUSE_W-1:0] flt_icode
);
  import xlat_pkg::*;

  logic [2:0]        d_kind;
  logic [EA_W-1:0]   d_raddr;
  logic [2:0]        d_perm;
  logic [LPID_W-1:0] d_lpid;
  logic [PID_W-1:0]  d_pid;
  logic              accept;
  logic              seg_data;
  logic              seg_any;

  assign req_ready = ~rsp_valid;
  assign accept    = req_valid & req_ready;
  assign seg_data  = accept & (d_kind == RK_DSEG);
  assign seg_any   = accept & ((d_kind == RK_DSEG) | (d_kind == RK_ISEG));

  xlat_mode_decode #(
    .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .REAL_CLR(REAL_CLR)
  ) u_dec (
    .ea(req_ea), .acc(req_acc), .hv(req_hv), .vhyp(req_vhyp),
    .ir(req_ir), .dr(req_dr), .cfg_lpid(cfg_lpid), .cfg_pid(cfg_pid),
    .kind(d_kind), .raddr(d_raddr), .perm(d_perm), .lpid(d_lpid), .pid(d_pid)
  );

  xlat_fault_regs #(
    .EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)
  ) u_flt (
    .clk(clk), .rst(rst), .seg_data(seg_data), .seg_any(seg_any), .seg_ea(req_ea),
    .sf_valid(sf_valid), .sf_acc(sf_acc), .sf_ea(sf_ea), .sf_cause(sf_cause),
    .flt_addr(flt_addr), .flt_status(flt_status), .flt_icode(flt_icode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_raddr <= '0;
      rsp_perm  <= '0;
      rsp_lpid  <= '0;
      rsp_pid   <= '0;
      rsp_ea    <= '0;
      rsp_acc   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_kind  <= d_kind;
      rsp_raddr <= d_raddr;
      rsp_perm  <= d_perm;
      rsp_lpid  <= d_lpid;
      rsp_pid   <= d_pid;
      rsp_ea    <= req_ea;
      rsp_acc   <= req_acc;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_ctx_checker.sv
module xlat_ctx_checker #(
  parameter int EA_W      = 64,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25,
  parameter int REAL_CLR  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [EA_W-1:0]    req_ea,
  input logic [1:0]         req_acc,
  input logic               req_hv,
  input logic               req_vhyp,
  input logic               req_ir,
  input logic               req_dr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [2:0]         rsp_kind,
  input logic [EA_W-1:0]    rsp_raddr,
  input logic [2:0]         rsp_perm,
  input logic               sf_valid,
  input logic [1:0]         sf_acc,
  input logic [EA_W-1:0]    sf_ea,
  input logic [EA_W-1:0]    flt_addr,
  input logic [CAUSE_W-1:0] flt_status,
  input logic [CAUSE_W-1:0] flt_icode
);
  localparam logic [EA_W-1:0] CLR_MASK = {{REAL_CLR{1'b0}}, {(EA_W-REAL_CLR){1'b1}}};

  logic acc_q, byp_q, dseg_q;
  assign acc_q  = req_valid & req_ready;
  assign byp_q  = (req_acc != 2'd3) & (req_hv | req_vhyp) &
                  ~((req_acc == 2'd2) ? req_ir : req_dr);
  assign dseg_q = acc_q & ~byp_q & ~req_hv & (req_acc inside {2'd0, 2'd1}) &
                  (req_ea[EA_W-1 -: 2] inside {2'd1, 2'd2});

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_raddr)));

  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_q && byp_q) |=> (rsp_kind == 3'd0 && rsp_perm == 3'b111 &&
                          rsp_raddr == ($past(req_ea) & CLR_MASK)));

  p_no_bypass_guest_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_q && !req_hv && !req_vhyp) |=> (rsp_kind != 3'd0));

  p_dseg_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (dseg_q && !sf_valid) |=> (rsp_kind == 3'd3 && flt_addr == $past(req_ea) && flt_icode == '0));

  p_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_q && req_acc == 2'd3 && !sf_valid) |=>
      (rsp_kind == 3'd4 && $stable(flt_addr) && $stable(flt_status) && $stable(flt_icode)));

  p_store_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (sf_valid && sf_acc == 2'd1) |=> (flt_status[STORE_BIT] && flt_addr == $past(sf_ea)));

  p_fetch_report_r10: assert property (@(posedge clk) disable iff (rst)
    (sf_valid && sf_acc == 2'd2 && !acc_q) |=> ($stable(flt_addr) && $stable(flt_status)));
endmodule

bind xlat_ctx_frontend xlat_ctx_checker #(
  .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .CAUSE_W(CAUSE_W),
  .STORE_BIT(STORE_BIT), .REAL_CLR(REAL_CLR)
) u_chk (.*);

// File: tb/tb_xlat_ctx_frontend.sv
module tb_xlat_ctx_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic        req_hv = 1'b0, req_vhyp = 1'b0, req_ir = 1'b0, req_dr = 1'b0;
  logic [11:0] cfg_lpid = 12'hA5C;
  logic [19:0] cfg_pid = 20'h3_1F2E;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [2:0]  rsp_kind;
  logic [63:0] rsp_raddr;
  logic [2:0]  rsp_perm;
  logic [11:0] rsp_lpid;
  logic [19:0] rsp_pid;
  logic [63:0] rsp_ea;
  logic [1:0]  rsp_acc;
  logic        sf_valid = 1'b0;
  logic [1:0]  sf_acc = '0;
  logic [63:0] sf_ea = '0;
  logic [31:0] sf_cause = '0;
  logic [63:0] flt_addr;
  logic [31:0] flt_status;
  logic [31:0] flt_icode;

  always #2 clk = ~clk;

  xlat_ctx_frontend dut (.*);

  typedef struct packed {
    logic [2:0]  kind;
    logic [63:0] raddr;
    logic [2:0]  perm;
    logic [11:0] lpid;
    logic [19:0] pid;
    logic [63:0] ea;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] ea, input logic [1:0] acc,
                                 input logic hv, input logic vh, input logic ir, input logic dr);
    exp_t e;
    logic reloc;
    e = '0;
    e.ea = ea;
    reloc = (acc == 2'd2) ? ir : dr;
    if (acc == 2'd3) e.kind = 3'd4;
    else if ((hv || vh) && !reloc) begin
      e.kind = 3'd0; e.raddr = {4'h0, ea[59:0]}; e.perm = 3'b111;
    end else if (hv) begin
      e.kind = 3'd1;
      case (ea[63:62])
        2'd0: e.pid = cfg_pid;
        2'd1: begin e.lpid = cfg_lpid; e.pid = cfg_pid; end
        2'd2: e.lpid = cfg_lpid;
        default: ;
      endcase
    end else begin
      case (ea[63:62])
        2'd0: begin e.kind = 3'd1; e.lpid = cfg_lpid; e.pid = cfg_pid; end
        2'd3: begin e.kind = 3'd1; e.lpid = cfg_lpid; end
        default: e.kind = (acc == 2'd2) ? 3'd2 : 3'd3;
      endcase
    end
    return e;
  endfunction

  task automatic send(input string tag, input logic [63:0] ea, input logic [1:0] acc,
                      input logic hv, input logic vh, input logic ir, input logic dr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_acc = acc;
    req_hv = hv; req_vhyp = vh; req_ir = ir; req_dr = dr;
    q.push_back(model(ea, acc, hv, vh, ir, dr));
    $display("send %s", tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic report(input logic [1:0] acc, input logic [63:0] ea, input logic [31:0] cause);
    @(negedge clk);
    sf_valid = 1'b1; sf_acc = acc; sf_ea = ea; sf_cause = cause;
    @(negedge clk);
    sf_valid = 1'b0;
  endtask

  // Monitor: applies back-pressure and compares each consumed response
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      n++;
      rsp_ready = (n % 3) != 0;
      if (rsp_valid && rsp_ready) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected response", 64'(rsp_kind), 64'hx);
        end else begin
          e = q.pop_front();
          chk(rsp_kind == e.kind, "R3-R8 kind", 64'(rsp_kind), 64'(e.kind));
          chk(rsp_raddr == e.raddr && rsp_perm == e.perm, "R3 raddr/perm", rsp_raddr, e.raddr);
          chk(rsp_lpid == e.lpid && rsp_pid == e.pid, "R5/R6 ids",
              {rsp_lpid, rsp_pid}, {e.lpid, e.pid});
          chk(rsp_ea == e.ea, "R2 ea passthrough", rsp_ea, e.ea);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] a0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 handshake idle", {rsp_valid, req_ready}, 64'h1);
    chk(flt_addr == 0 && flt_status == 0 && flt_icode == 0, "R1 fault regs", flt_addr, 64'h0);
    rst = 1'b0;

    // R3 / R4 bypass selection
    send("R3 hv data bypass", 64'hFEDC_BA98_7654_3210, 2'd0, 1, 0, 1, 0);
    send("R4 hv fetch ir off", 64'h8000_0000_0000_1000, 2'd2, 1, 0, 0, 1);
    send("R4 hv fetch ir on", 64'h4000_0000_0000_2000, 2'd2, 1, 0, 1, 0);
    send("R3 vhyp guest write", 64'hC123_0000_0000_0040, 2'd1, 0, 1, 1, 0);
    send("R4 plain guest dr off", 64'h0000_0000_0000_3000, 2'd0, 0, 0, 0, 0);
    // R5 hypervisor quadrants
    for (int qd = 0; qd < 4; qd++)
      send("R5 hv quadrant", {2'(qd), 62'h0_1234_5678}, 2'd0, 1, 0, 1, 1);
    // R6 guest legal quadrants
    send("R6 guest q0", 64'h0000_7777_0000_0000, 2'd1, 0, 0, 1, 1);
    send("R6 guest q3", 64'hC000_0000_ABCD_0000, 2'd2, 0, 0, 1, 1);
    drain();

    // R9 data storage reports
    report(2'd1, 64'h1111_2222_3333_4444, 32'h4000_0000);
    chk(flt_status == 32'h4200_0000, "R9 store flag", 64'(flt_status), 64'h4200_0000);
    chk(flt_addr == 64'h1111_2222_3333_4444, "R9 address", flt_addr, 64'h1111_2222_3333_4444);
    report(2'd0, 64'h5555_6666_7777_8888, 32'h0800_0000);
    chk(flt_status == 32'h0800_0000, "R9 read no store flag", 64'(flt_status), 64'h0800_0000);
    // R10 fetch report keeps data regs
    report(2'd2, 64'h9999_0000_0000_0000, 32'h1000_0004);
    chk(flt_icode == 32'h1000_0004, "R10 icode", 64'(flt_icode), 64'h1000_0004);
    chk(flt_addr == 64'h5555_6666_7777_8888 && flt_status == 32'h0800_0000, "R10 data regs kept",
        flt_addr, 64'h5555_6666_7777_8888);
    report(2'd3, 64'hDEAD_0000_0000_0000, 32'hFFFF_FFFF);
    chk(flt_addr == 64'h5555_6666_7777_8888 && flt_status == 32'h0800_0000 &&
        flt_icode == 32'h1000_0004, "R10 code 3 ignored", 64'(flt_icode), 64'h1000_0004);

    // R7 guest illegal quadrants
    send("R7 guest q2 fetch", 64'h8000_0000_0000_5000, 2'd2, 0, 0, 1, 1);
    drain();
    chk(flt_icode == 0, "R7 iseg clears icode", 64'(flt_icode), 64'h0);
    chk(flt_addr == 64'h5555_6666_7777_8888, "R7 iseg leaves addr", flt_addr, 64'h5555_6666_7777_8888);
    report(2'd2, 64'h0, 32'h0000_0077);
    a0 = 64'h4ABC_0000_0000_6000;
    send("R7 guest q1 read", a0, 2'd0, 0, 0, 1, 1);
    drain();
    chk(flt_addr == a0, "R7 dseg address", flt_addr, a0);
    chk(flt_icode == 0, "R7 dseg clears icode", 64'(flt_icode), 64'h0);

    // R8 illegal access code
    send("R8 illegal code", 64'h0000_0000_0000_7000, 2'd3, 1, 0, 0, 0);
    drain();
    chk(flt_addr == a0 && flt_status == 32'h0800_0000, "R8 regs unchanged", flt_addr, a0);

    // R2 back-to-back traffic
    for (int i = 0; i < 6; i++)
      send("R2 burst", {2'(i), 62'(i * 64'h1_0001)}, 2'(i % 3), 1'(i[0]), 0, 1'(i[1]), 1'(i[2]));
    drain();
    chk(q.size() == 0 && req_ready, "R2 all responses consumed", 64'(q.size()), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule